// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block sits between a processor register port and an embedded flash macro. It decides whether a requested program, erase or verify mode may go ahead. Software writes a control register carrying four request bits: program, erase, program-verify and erase-verify. Two block-select registers hold one erase-enable bit per flash block. An emulation register holds a lock bit, set while a RAM overlay stands in for flash. The block drives the active mode and a registered per-block erase strobe vector to the flash macro.

Protection acts in two ways. The block-select bits gate erase only, and they have no effect on programming. The emulation lock refuses both program and erase for every block, whatever the select bits hold. Verify modes stay available in every case. A refused request, or a write that asks for program and erase together, sets a sticky flag in a status register. Reading that register clears the flags.

A separate operational reset input is filtered. It takes effect only after it has been held low for a minimum number of consecutive clocks (default 20). A shorter pulse changes nothing. The asynchronous `rst_n` is the power-on reset.

Top module: `flash_pe_guard`

## Requirements
- R1: Registers are at these addresses: 0 = control (bit0 program, bit1 erase, bit2 program-verify, bit3 erase-verify), 1 = select for blocks 0..7, 2 = select for blocks 8..15, 3 = emulation (bit0 lock), 4 = status (bit0 violation, bit1 request error). Reads return the register in the cycle after `rd_en`, with unused bits zero. Addresses 5..7 read zero.
- R2: With the lock clear, a control write with program alone enters mode PROGRAM (code 1) on the clock after the register updates, whatever the select bits hold.
- R3: With the lock clear, erase alone enters ERASE (code 2) only when at least one select bit is 1. With all select bits zero the mode stays IDLE (code 0).
- R4: With the emulation lock set, neither program nor erase is entered, whatever the select bits hold.
- R5: Program-verify gives mode 3 and erase-verify gives mode 4, with or without protection. A program or erase bit takes precedence over both verify bits, and program-verify takes precedence over erase-verify.
- R6: A control write with program and erase both set leaves the mode IDLE and sets the request-error flag.
- R7: A control write that asks for program or erase alone and is refused by protection sets the violation flag.
- R8: A status read returns the flags and clears them on the same clock, unless a new event sets a flag on that clock.
- R9: `blk_erase[i]` is 1 exactly when, one clock earlier, the mode was ERASE, the lock was clear and select bit i was 1.
- R10: Clearing the program or erase bit returns the mode to IDLE, or to the verify mode that is still requested.
- R11: An operational reset held low for 20 consecutive clocks clears all registers, flags, the mode and the strobes. A pulse of 19 clocks or fewer changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| op_rst_n | input | 1 | Active-low operational reset, filtered by length |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| mode | output | 3 | Active flash mode code |
| blk_erase | output | 16 | Per-block erase strobes |
| viol_flag | output | 1 | Sticky protection-violation flag |
| req_err_flag | output | 1 | Sticky conflicting-request flag |

## Verification
A wrong protection decision shows on `mode` two clocks after the offending write. The decision could be wrong because of a mis-latched lock bit, a select register written into the wrong half, or an inverted all-zero test. The same fault shows on `blk_erase` one clock after that. A flag that fails to set or clear is visible on its port right away, and on the next status read. A reset filter with the wrong count shows up as register contents that survive, or are lost, after pulses of exactly 19 and 20 clocks. Random register traffic with a dense share of all-zero select values and lock toggles drives the gating terms through every combination. After each operation the ports are compared against a bench model.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_PROG  = 3'd1,
    MODE_ERASE = 3'd2,
    MODE_PVER  = 3'd3,
    MODE_EVER  = 3'd4
  } mode_e;

  localparam int ADDR_W = 3;
  localparam int CTRL_W = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_SLO  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SHI  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_EMU  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd4;

  localparam int BIT_P  = 0;
  localparam int BIT_E  = 1;
  localparam int BIT_PV = 2;
  localparam int BIT_EV = 3;
endpackage

// File: rtl/fpg_rst_filter.sv
module fpg_rst_filter #(
  parameter int MIN_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_rst_n,
  output logic srst_o
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (op_rst_n) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != CMAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign srst_o = (cnt_q == CMAX);

  // R11
  srst_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> $past(!op_rst_n));
endmodule

// File: rtl/fpg_regs.sv
module fpg_regs
  import fpg_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LO_BLKS = 8,
  parameter int HI_BLKS = 8,
  localparam int NBLK   = LO_BLKS + HI_BLKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [NBLK-1:0]   sel_q,
  output logic              emu_q,
  output logic              viol_q,
  output logic              rerr_q,
  output logic [DW-1:0]     rdata_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic [NBLK-1:0]   sel_d;
  logic              emu_d, viol_d, rerr_d;
  logic [DW-1:0]     rdata_d, rmux;
  logic              wr_ctrl, wr_slo, wr_shi, wr_emu, rd_stat;
  logic              p_w, e_w, both, refuse;
  logic              ctrl_en, sel_en, emu_en, flag_en;

  always_comb begin
    wr_ctrl = wr_en && (addr == ADR_CTRL);
    wr_slo  = wr_en && (addr == ADR_SLO);
    wr_shi  = wr_en && (addr == ADR_SHI);
    wr_emu  = wr_en && (addr == ADR_EMU);
    rd_stat = rd_en && (addr == ADR_STAT);
    p_w     = wdata[BIT_P];
    e_w     = wdata[BIT_E];
    both    = wr_ctrl && p_w && e_w;
    refuse  = wr_ctrl && (p_w ^ e_w) &&
              ((p_w && emu_q) || (e_w && (emu_q || (sel_q == '0))));
  end

  always_comb begin
    ctrl_en = wr_ctrl || srst;
    ctrl_d  = srst ? '0 : wdata[CTRL_W-1:0];
    sel_en  = wr_slo || wr_shi || srst;
    sel_d   = sel_q;
    if (srst)        sel_d = '0;
    else if (wr_slo) sel_d[LO_BLKS-1:0] = wdata[LO_BLKS-1:0];
    else if (wr_shi) sel_d[NBLK-1:LO_BLKS] = wdata[HI_BLKS-1:0];
    emu_en  = wr_emu || srst;
    emu_d   = srst ? 1'b0 : wdata[0];
  end

  always_comb begin
    flag_en = srst || refuse || both || rd_stat;
    if (srst) begin
      viol_d = 1'b0;
      rerr_d = 1'b0;
    end else begin
      viol_d = refuse ? 1'b1 : (rd_stat ? 1'b0 : viol_q);
      rerr_d = both   ? 1'b1 : (rd_stat ? 1'b0 : rerr_q);
    end
  end

  always_comb begin
    rmux = '0;
    case (addr)
      ADR_CTRL: rmux[CTRL_W-1:0]  = ctrl_q;
      ADR_SLO:  rmux[LO_BLKS-1:0] = sel_q[LO_BLKS-1:0];
      ADR_SHI:  rmux[HI_BLKS-1:0] = sel_q[NBLK-1:LO_BLKS];
      ADR_EMU:  rmux[0]           = emu_q;
      ADR_STAT: rmux[1:0]         = {rerr_q, viol_q};
      default:  rmux              = '0;
    endcase
    rdata_d = srst ? '0 : rmux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sel_q   <= '0;
      emu_q   <= 1'b0;
      viol_q  <= 1'b0;
      rerr_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (ctrl_en)        ctrl_q  <= ctrl_d;
      if (sel_en)         sel_q   <= sel_d;
      if (emu_en)         emu_q   <= emu_d;
      if (flag_en)        viol_q  <= viol_d;
      if (flag_en)        rerr_q  <= rerr_d;
      if (rd_en || srst)  rdata_q <= rdata_d;
    end
  end

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !wr_en) |=> (!viol_q && !rerr_q));

  // R7
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refuse && !srst) |=> viol_q);
endmodule

// File: rtl/fpg_mode_fsm.sv
module fpg_mode_fsm
  import fpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              sel_any_i,
  input  logic              emu_i,
  output mode_e             mode_q
);
  mode_e mode_d;
  logic  p, e, pv, ev;

  always_comb begin
    p  = ctrl_i[BIT_P];
    e  = ctrl_i[BIT_E];
    pv = ctrl_i[BIT_PV];
    ev = ctrl_i[BIT_EV];
    mode_d = MODE_IDLE;
    if (srst)               mode_d = MODE_IDLE;
    else if (p && e)        mode_d = MODE_IDLE;
    else if (p)             mode_d = emu_i ? MODE_IDLE : MODE_PROG;
    else if (e)             mode_d = (emu_i || !sel_any_i) ? MODE_IDLE : MODE_ERASE;
    else if (pv)            mode_d = MODE_PVER;
    else if (ev)            mode_d = MODE_EVER;
    else                    mode_d = MODE_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_IDLE;
    else        mode_q <= mode_d;
  end

  // R4
  lock_blocks_pe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_i |=> (mode_q != MODE_PROG && mode_q != MODE_ERASE));

  // R3
  no_sel_no_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_any_i |=> (mode_q != MODE_ERASE));

  // R6
  both_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[BIT_P] && ctrl_i[BIT_E]) |=> (mode_q == MODE_IDLE));
endmodule

// File: rtl/fpg_erase_strobe.sv
module fpg_erase_strobe #(
  parameter int NBLK = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            srst,
  input  logic            erase_act_i,
  input  logic            emu_i,
  input  logic [NBLK-1:0] sel_i,
  output logic [NBLK-1:0] blk_q
);
  logic gate;
  assign gate = erase_act_i && !emu_i && !srst;

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    logic d;
    assign d = gate && sel_i[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk_q[i] <= 1'b0;
      else        blk_q[i] <= d;
    end
  end

  // R9
  strobe_in_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q != '0) |-> $past(erase_act_i));
endmodule

// File: rtl/flash_pe_guard.sv
module flash_pe_guard
  import fpg_pkg::*;
#(
  parameter int DW      = 8,
  parameter int LO_BLKS = 8,
  parameter int HI_BLKS = 8,
  parameter int MIN_RST = 20,
  localparam int NBLK   = LO_BLKS + HI_BLKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic [2:0]        mode,
  output logic [NBLK-1:0]   blk_erase,
  output logic              viol_flag,
  output logic              req_err_flag
);
  logic              srst;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NBLK-1:0]   sel_q;
  logic              emu_q;
  mode_e             mode_q;

  fpg_rst_filter #(.MIN_CYC(MIN_RST)) u_rstf (
    .clk(clk), .rst_n(rst_n), .op_rst_n(op_rst_n), .srst_o(srst)
  );

  fpg_regs #(.DW(DW), .LO_BLKS(LO_BLKS), .HI_BLKS(HI_BLKS)) u_regs (
    .clk(clk), .rst_n(rst_n), .srst(srst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .ctrl_q(ctrl_q), .sel_q(sel_q),
    .emu_q(emu_q), .viol_q(viol_flag), .rerr_q(req_err_flag), .rdata_q(rdata)
  );

  fpg_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .srst(srst), .ctrl_i(ctrl_q),
    .sel_any_i(sel_q != '0), .emu_i(emu_q), .mode_q(mode_q)
  );

  fpg_erase_strobe #(.NBLK(NBLK)) u_strb (
    .clk(clk), .rst_n(rst_n), .srst(srst),
    .erase_act_i(mode_q == MODE_ERASE), .emu_i(emu_q),
    .sel_i(sel_q), .blk_q(blk_erase)
  );

  assign mode = mode_q;
endmodule

// File: tb/flash_pe_guard_tb.sv
`timescale 1ns/1ps
module flash_pe_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_rst_n = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  mode;
  logic [15:0] blk_erase;
  logic        viol_flag, req_err_flag;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [3:0]  m_ctrl;
  logic [15:0] m_sel;
  logic        m_emu, m_viol, m_rerr;

  always #2 clk = ~clk;

  flash_pe_guard u_dut (
    .clk(clk), .rst_n(rst_n), .op_rst_n(op_rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .mode(mode),
    .blk_erase(blk_erase), .viol_flag(viol_flag), .req_err_flag(req_err_flag)
  );

  function automatic logic [2:0] exp_mode();
    if (m_ctrl[0] && m_ctrl[1]) return 3'd0;
    if (m_ctrl[0]) return m_emu ? 3'd0 : 3'd1;
    if (m_ctrl[1]) return (m_emu || m_sel == 0) ? 3'd0 : 3'd2;
    if (m_ctrl[2]) return 3'd3;
    if (m_ctrl[3]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic logic [15:0] exp_strobe();
    return (exp_mode() == 3'd2 && !m_emu) ? m_sel : 16'h0;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {4'h0, m_ctrl};
      3'd1: return m_sel[7:0];
      3'd2: return m_sel[15:8];
      3'd3: return {7'h0, m_emu};
      3'd4: return {6'h0, m_rerr, m_viol};
      default: return 8'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_ctrl = '0; m_sel = '0; m_emu = 0; m_viol = 0; m_rerr = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      3'd0: begin
        if (d[0] && d[1]) m_rerr = 1;
        else if (d[0] && m_emu) m_viol = 1;
        else if (d[1] && (m_emu || m_sel == 0)) m_viol = 1;
        m_ctrl = d[3:0];
      end
      3'd1: m_sel[7:0]  = d;
      3'd2: m_sel[15:8] = d;
      3'd3: m_emu = d[0];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    check(req, rdata, exp_rd(a));
    if (a == 3'd4) begin m_viol = 0; m_rerr = 0; end
  endtask

  task automatic settle_chk(input string req);
    @(negedge clk); @(negedge clk);
    check({req, " mode"}, mode, exp_mode());
    check({req, " strobe"}, blk_erase, exp_strobe());
    check({req, " flags"}, {req_err_flag, viol_flag}, {m_rerr, m_viol});
  endtask

  task automatic op_pulse(input int n);
    @(negedge clk); op_rst_n = 0;
    repeat (n) @(negedge clk);
    op_rst_n = 1;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset mode", mode, 0);
    check("R1 reset strobe", blk_erase, 0);
    check("R1 reset flags", {req_err_flag, viol_flag}, 0);
    for (int a = 0; a < 8; a++) rd_chk("R1 reset read", 3'(a));

    // R3 erase with no block selected is refused; R7 flag
    wr(3'd0, 8'h02); settle_chk("R3 erase nosel");
    check("R7 viol", viol_flag, 1);
    rd_chk("R8 status read", 3'd4);
    check("R8 cleared", {req_err_flag, viol_flag}, 0);
    // R2 program ignores select
    wr(3'd0, 8'h01); settle_chk("R2 program");
    check("R2 mode prog", mode, 1);
    // R10 clear returns idle
    wr(3'd0, 8'h00); settle_chk("R10 idle");
    // R3/R9 erase with selection
    wr(3'd1, 8'h81); wr(3'd2, 8'h40);
    wr(3'd0, 8'h02); settle_chk("R9 erase strobe");
    check("R9 strobe value", blk_erase, 16'h4081);
    // R4 lock during erase
    wr(3'd3, 8'h01); settle_chk("R4 lock erase");
    wr(3'd0, 8'h01); settle_chk("R4 lock prog");
    check("R7 viol lock", viol_flag, 1);
    // R5 verify under lock
    wr(3'd0, 8'h04); settle_chk("R5 pver locked");
    wr(3'd0, 8'h08); settle_chk("R5 ever locked");
    wr(3'd0, 8'h0C); settle_chk("R5 verify prio");
    // R6 both
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h03); settle_chk("R6 both");
    check("R6 rerr", req_err_flag, 1);
    rd_chk("R8 status both", 3'd4);
    // R5 program precedes verify
    wr(3'd0, 8'h05); settle_chk("R5 prog over verify");
    // R10 drop program keeps verify
    wr(3'd0, 8'h04); settle_chk("R10 to verify");

    // R11 short pulse ignored, full pulse honoured
    wr(3'd1, 8'h5A); wr(3'd0, 8'h01);
    op_pulse(19);
    rd_chk("R11 short pulse sel", 3'd1);
    check("R11 short pulse mode", mode, 1);
    op_pulse(20);
    model_clear();
    rd_chk("R11 full pulse sel", 3'd1);
    rd_chk("R11 full pulse ctrl", 3'd0);
    settle_chk("R11 full pulse");

    // random traffic R1..R10
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 6) begin
        logic [2:0] a = 3'($urandom_range(0, 3));
        logic [7:0] d = 8'($urandom);
        if (a != 3'd0 && $urandom_range(0, 3) == 0) d = 8'h00;
        if (a == 3'd3) d = {7'h0, ($urandom_range(0, 2) == 0)};
        wr(a, d);
        settle_chk("R3 R4 R9 random");
      end else begin
        rd_chk("R1 R8 random read", 3'($urandom_range(0, 7)));
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule